// File: doc/BRIEF.md
# Row-Fetch Nibble Stream Memory

This block is a small on-chip memory that drives a 4-bit output stream. Each storage row is 32 bits wide and holds eight 4-bit nibbles. While a stream runs, the array is read only once for every eight output cycles. The row that was read goes into a holding register. A 3-bit select counter then steps a multiplexer through that row, so one nibble leaves per cycle at the full output rate. The wide memory is therefore switched at one eighth of the rate that a nibble-at-a-time memory would need.

A host loads rows through a write port while the block is idle. A start command gives a base row and a number of rows. The block then sends the rows in order, with no gap between them, and raises a valid strobe for each nibble. The next row is read during the last nibble cycle of the current row and lands in the holding register exactly at the wrap of the select counter. A write that arrives while a stream runs is dropped and flagged with a one-cycle error pulse.

Top module: `nibble_stream_mem`

## Requirements
- R1: After reset, `nib_valid` and `wr_err` are 0. They stay 0 until a start command or a write attempt occurs.
- R2: Within a row, nibbles leave least significant first. Nibble k is bits [4k+3:4k] of the 32-bit row, and nibble 0 appears in the cycle after the start edge.
- R3: The rows of a stream follow one another with no idle cycle. The row address increments after each row and wraps from the last row of the array to row 0.
- R4: After an accepted start with row count N, `nib_valid` is high for exactly 8*N consecutive cycles and then drops. It drops only after the eighth nibble of a row.
- R5: A start command with a row count of 0 is ignored and `nib_valid` stays low.
- R6: A start command issued while a stream runs is ignored. The running stream keeps its rows, its order and its length.
- R7: A write attempted while a stream runs leaves the memory unchanged. It produces `wr_err` high for exactly the one cycle after the write edge, and `wr_err` is high at no other time.
- R8: A write while no stream runs stores `wr_data` at `wr_addr` and raises no error. A later stream of that row returns the written nibbles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write request |
| wr_addr | input | ADDR_W | Row to write |
| wr_data | input | NIB_W*NIBS | Row contents, nibble 0 in the low bits |
| start | input | 1 | Start a stream (ignored while busy or when the count is 0) |
| start_row | input | ADDR_W | First row of the stream |
| start_rows | input | CNT_W | Number of rows to stream |
| nib_out | output | NIB_W | Current output nibble |
| nib_valid | output | 1 | High while `nib_out` carries stream data |
| wr_err | output | 1 | One-cycle pulse after a write attempted during a stream |

## Verification
The hardest case to reach from the ports is a command that collides with a running stream. A start or a write must land in the middle of a row, on a chosen nibble cycle, and its effect shows only indirectly. The stimulus injects the colliding command at a fixed nibble index inside a stream. It checks that the stream runs on unchanged, and then streams the targeted row afterwards to show that the dropped write never reached the array. The sweep over every base row and counts up to ten also drives the address wrap and the back-to-back row hand-off at every row position.

// File: rtl/nibble_stream_mem.sv
module nibble_stream_mem #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8,
  parameter int NIB_W  = 4,
  parameter int NIBS   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [NIB_W*NIBS-1:0]   wr_data,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       start_row,
  input  logic [CNT_W-1:0]        start_rows,
  output logic [NIB_W-1:0]        nib_out,
  output logic                    nib_valid,
  output logic                    wr_err
);
  localparam int ROW_W = NIB_W * NIBS;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SEL_W = (NIBS > 1) ? $clog2(NIBS) : 1;
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NIBS - 1);

  logic [ROW_W-1:0]  mem [DEPTH];
  logic [ROW_W-1:0]  row_q;
  logic [SEL_W-1:0]  sel;
  logic [ADDR_W-1:0] row_ptr;
  logic [CNT_W-1:0]  rows_left;
  logic              busy;

  wire last_nib  = (sel == LAST_SEL);
  wire last_row  = (rows_left == CNT_W'(1));
  wire go        = start && !busy && (start_rows != '0);
  wire wrap      = busy && last_nib && !last_row;
  wire [ADDR_W-1:0] fetch_addr = go ? start_row : row_ptr + 1'b1;

  always_ff @(posedge clk)
    if (wr_en && !busy) mem[wr_addr] <= wr_data;

  always_ff @(posedge clk)
    if (go || wrap) row_q <= mem[fetch_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sel       <= '0;
      row_ptr   <= '0;
      rows_left <= '0;
      wr_err    <= 1'b0;
    end else begin
      wr_err <= wr_en && busy;
      if (go) begin
        busy      <= 1'b1;
        sel       <= '0;
        row_ptr   <= start_row;
        rows_left <= start_rows;
      end else if (busy) begin
        sel <= sel + 1'b1;
        if (last_nib) begin
          sel <= '0;
          if (last_row) begin
            busy      <= 1'b0;
            rows_left <= '0;
          end else begin
            rows_left <= rows_left - 1'b1;
            row_ptr   <= row_ptr + 1'b1;
          end
        end
      end
    end
  end

  assign nib_out   = row_q[sel*NIB_W +: NIB_W];
  assign nib_valid = busy;

  assert_first_nibble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> sel == '0);
  assert_row_latch_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sel != '0) |-> $stable(row_q));
  assert_end_on_row_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(sel) == LAST_SEL);
  assert_count_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rows_left != '0);
  assert_zero_count_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && start_rows == '0) |=> !busy);
  assert_err_only_streaming_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(busy));
endmodule

// File: tb/nibble_stream_mem_tb.sv
module nibble_stream_mem_tb;
  localparam int AW = 3;
  localparam int CW = 4;
  localparam int ROWS = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, start = 0;
  logic [AW-1:0] wr_addr = '0, start_row = '0;
  logic [31:0] wr_data = '0;
  logic [CW-1:0] start_rows = '0;
  logic [3:0] nib_out;
  logic nib_valid, wr_err;

  int errors = 0, checks = 0;
  logic [31:0] model [ROWS];

  always #5 clk = ~clk;

  nibble_stream_mem #(.ADDR_W(AW), .CNT_W(CW), .NIB_W(4), .NIBS(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .start_row(start_row), .start_rows(start_rows),
    .nib_out(nib_out), .nib_valid(nib_valid), .wr_err(wr_err));

  function automatic logic [31:0] pat(input int r, input int s);
    logic [31:0] w;
    for (int k = 0; k < 8; k++) w[k*4 +: 4] = 4'((r*7 + k*3 + s) % 16);
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic host_write(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
    chk(wr_err == 1'b0, "R8 no error on idle write", wr_err, 0);
    model[a] = d;
  endtask

  // kind 0: plain, 1: start injected at nibble inj, 2: write injected at nibble inj
  task automatic stream(input int r, input int n, input int kind, input int inj, input int wa);
    @(negedge clk); start = 1; start_row = AW'(r); start_rows = CW'(n);
    @(negedge clk); start = 0;
    for (int i = 0; i < 8*n; i++) begin
      int row = (r + i/8) % ROWS;
      int exp = int'((model[row] >> (4*(i%8))) & 32'hF);
      chk(nib_valid == 1'b1, "R4 valid held", nib_valid, 1);
      chk(nib_out == 4'(exp), (i < 8) ? "R2 nibble order" : "R3 row sequence", nib_out, exp);
      chk(wr_err == (kind == 2 && i == inj + 1), "R7 error pulse", wr_err, (kind == 2 && i == inj + 1));
      if (kind == 1 && i == inj) begin start = 1; start_row = AW'(r + 3); start_rows = CW'(1); end
      if (kind == 2 && i == inj) begin wr_en = 1; wr_addr = AW'(wa); wr_data = 32'hFFFF_FFFF; end
      if (i == inj + 1) begin start = 0; wr_en = 0; end
      @(negedge clk);
      start = 0; wr_en = 0;
    end
    chk(nib_valid == 1'b0, "R4 valid drops after 8*N", nib_valid, 0);
    chk(wr_err == 1'b0, "R7 no stray error", wr_err, 0);
    @(negedge clk);
    chk(nib_valid == 1'b0, (kind == 1) ? "R6 injected start ignored" : "R4 stays idle", nib_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(nib_valid == 1'b0, "R1 valid low in reset", nib_valid, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(nib_valid == 1'b0, "R1 valid low after reset", nib_valid, 0);
    chk(wr_err == 1'b0, "R1 error low after reset", wr_err, 0);

    for (int r = 0; r < ROWS; r++) host_write(r, pat(r, 1));

    // R2 R3 R4: every base row, counts 1..10 (covers wrap)
    for (int r = 0; r < ROWS; r++)
      for (int n = 1; n <= 10; n++) stream(r, n, 0, -5, 0);

    // R5: zero count ignored
    @(negedge clk); start = 1; start_row = 3; start_rows = 0;
    @(negedge clk); start = 0;
    for (int i = 0; i < 4; i++) begin
      chk(nib_valid == 1'b0, "R5 zero count ignored", nib_valid, 0);
      @(negedge clk);
    end

    // R6: start while streaming
    stream(1, 2, 1, 5, 0);
    stream(6, 3, 1, 12, 0);

    // R7: write while streaming, then confirm target unchanged
    stream(2, 2, 2, 9, 4);
    stream(4, 1, 0, -5, 0);
    stream(0, 1, 2, 0, 0);
    stream(0, 1, 0, -5, 0);

    // R8: idle overwrite is visible in a later stream
    host_write(5, 32'h7654_3210);
    stream(5, 1, 0, -5, 0);
    host_write(7, pat(7, 9));
    stream(6, 3, 0, -5, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule